// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block guesses where an indirect branch will jump. It keeps a direct-mapped table of target addresses indexed by a slice of the branch instruction address. Each request carries the branch address and the target that the branch actually resolved to. The block reads the stored target as its prediction and compares it with the resolved target. One cycle later it reports the prediction and a mispredict flag. In the same cycle as the lookup it writes the resolved target into the entry, so the entry always holds the most recent target seen at that index.

Entries carry neither a tag nor a valid bit. Any branches whose addresses select the same entry therefore share it and replace each other's targets. An entry that has never been written holds zero and acts as a prediction of zero. A synchronous reset starts a sweep that zeroes every entry, one per cycle. While the sweep runs, `ready` is low and requests are dropped. The index skips the low address bits that instruction alignment always keeps at zero. The number of skipped bits (0, 1 or 2) is a parameter, as are the address width, the target width and the index width.

Top module: `ibr_target_pred`

## Requirements
- R1: After reset is released, `ready` stays low for exactly DEPTH = 2^IDX_W clock cycles and then goes high. During reset and for the whole sweep, `rspValid` is 0.
- R2: A request made while `ready` is low produces no response and leaves the table unchanged.
- R3: A request accepted at a clock edge (`reqValid` high and `ready` high) raises `rspValid` for exactly the following cycle. With no accepted request, `rspValid` is 0.
- R4: The entry index is the IDX_W address bits starting at bit ALIGN_SHIFT, that is `reqAddr[ALIGN_SHIFT +: IDX_W]`. With the defaults this is `reqAddr[10:2]`.
- R5: `rspPredTarget` is the target stored in the indexed entry when the request was accepted. `rspMiss` is 1 exactly when that target differs from the request's `reqTarget`.
- R6: Every accepted request writes its `reqTarget` into the indexed entry, whether the prediction was right or wrong.
- R7: After the sweep, every entry holds zero. The first lookup of any index predicts 0, and it reports a hit only if the resolved target is 0.
- R8: Addresses that differ only in bits outside the index field select the same entry. They overwrite each other's targets.
- R9: Two accepted requests to the same index in back-to-back cycles: the second one is predicted with the target written by the first.
- R10: A reset asserted after entries have been written clears all of them to zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the clearing sweep |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Branch instruction address |
| reqTarget | input | TGT_W | Resolved branch target |
| ready | output | 1 | High when requests are accepted (table clear finished) |
| rspValid | output | 1 | Response strobe, one cycle after an accepted request |
| rspMiss | output | 1 | 1 = stored target differed from the resolved target |
| rspPredTarget | output | TGT_W | Predicted (previously stored) target |

## Verification
The lookup path is driven with several patterns:
- A repeated target on one branch, which tells a hit apart from a miss.
- A changing target on one branch, which shows that an entry is overwritten after a miss as well as after a hit.
- Two addresses that alias, one differing above the index field and one differing below it, which shows that tag-less sharing and the index slice are both in place.
- Back-to-back lookups of one index, which show whether the second read sees the first write or a stale value.
- Two scenarios around reset. A request dropped during the sweep must leave its entry at zero. A reset in mid-run must wipe entries written earlier.

// File: rtl/ibr_target_pred_pkg.sv
package ibr_target_pred_pkg;
  typedef struct packed {
    logic lookup;   // accepted request: compare and write resolved target
    logic clearWr;  // sweep write of zero to clearIdx
  } ctlStrobes_t;
endpackage

// File: rtl/ibr_target_pred_ctl.sv
module ibr_target_pred_ctl
  import ibr_target_pred_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             ready,
  output ctlStrobes_t      strobes,
  output logic [IDX_W-1:0] clearIdx
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic clearing;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clearIdx <= '0;
    end else if (clearing) begin
      clearIdx <= clearIdx + 1'b1;
      if (clearIdx == LAST_IDX) clearing <= 1'b0;
    end
  end

  assign ready = !clearing;

  always_comb begin
    strobes.clearWr = clearing && !rst;
    strobes.lookup  = reqValid && !clearing && !rst;
  end
endmodule

// File: rtl/ibr_target_pred_dp.sv
module ibr_target_pred_dp
  import ibr_target_pred_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TGT_W       = 32,
  parameter int IDX_W       = 9,
  parameter int ALIGN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [IDX_W-1:0]  clearIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TGT_W-1:0]  reqTarget,
  output logic              rspValid,
  output logic              rspMiss,
  output logic [TGT_W-1:0]  rspPredTarget
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TGT_W-1:0] targetTable [DEPTH];
  logic [IDX_W-1:0] lookIdx;
  logic [TGT_W-1:0] storedTgt;

  generate
    if (ALIGN_SHIFT == 0) begin : g_idxNoShift
      assign lookIdx = reqAddr[IDX_W-1:0];
    end else begin : g_idxShift
      assign lookIdx = reqAddr[ALIGN_SHIFT +: IDX_W];
    end
  endgenerate

  assign storedTgt = targetTable[lookIdx];

  always_ff @(posedge clk) begin
    if (strobes.clearWr) begin
      targetTable[clearIdx] <= '0;
    end else if (strobes.lookup) begin
      targetTable[lookIdx] <= reqTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid      <= 1'b0;
      rspMiss       <= 1'b0;
      rspPredTarget <= '0;
    end else begin
      rspValid <= strobes.lookup;
      if (strobes.lookup) begin
        rspMiss       <= (storedTgt != reqTarget);
        rspPredTarget <= storedTgt;
      end
    end
  end
endmodule

// File: rtl/ibr_target_pred.sv
module ibr_target_pred
  import ibr_target_pred_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TGT_W       = 32,
  parameter int IDX_W       = 9,
  parameter int ALIGN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TGT_W-1:0]  reqTarget,
  output logic              ready,
  output logic              rspValid,
  output logic              rspMiss,
  output logic [TGT_W-1:0]  rspPredTarget
);
  ctlStrobes_t      strobes;
  logic [IDX_W-1:0] clearIdx;

  ibr_target_pred_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .ready(ready), .strobes(strobes), .clearIdx(clearIdx)
  );

  ibr_target_pred_dp #(
    .ADDR_W(ADDR_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .ALIGN_SHIFT(ALIGN_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .clearIdx(clearIdx),
    .reqAddr(reqAddr), .reqTarget(reqTarget),
    .rspValid(rspValid), .rspMiss(rspMiss), .rspPredTarget(rspPredTarget)
  );
endmodule

// File: rtl/ibr_target_pred_chk.sv
module ibr_target_pred_chk #(
  parameter int ADDR_W      = 32,
  parameter int TGT_W       = 32,
  parameter int IDX_W       = 9,
  parameter int ALIGN_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [TGT_W-1:0]  reqTarget,
  input logic              ready,
  input logic              rspValid,
  input logic              rspMiss,
  input logic [TGT_W-1:0]  rspPredTarget
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] sinceReset;
  logic             accept;
  logic             r1Fire, r2Fire;
  logic [IDX_W-1:0] r1Idx, r2Idx;
  logic [TGT_W-1:0] r1Tgt, r2Tgt;

  assign accept = reqValid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceReset <= '0;
      r1Fire <= 1'b0; r2Fire <= 1'b0;
      r1Idx  <= '0;   r2Idx  <= '0;
      r1Tgt  <= '0;   r2Tgt  <= '0;
    end else begin
      if (sinceReset != CNT_W'(DEPTH)) sinceReset <= sinceReset + 1'b1;
      r1Fire <= accept;
      r1Idx  <= reqAddr[ALIGN_SHIFT +: IDX_W];
      r1Tgt  <= reqTarget;
      r2Fire <= r1Fire;
      r2Idx  <= r1Idx;
      r2Tgt  <= r1Tgt;
    end
  end

  // R1: ready only once the sweep length has elapsed since reset
  assert_ready_after_sweep_R1: assert property (@(posedge clk) disable iff (rst)
    ready == (sinceReset == CNT_W'(DEPTH)));

  // R2: a blocked request yields no response
  assert_blocked_no_resp_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !ready) |=> !rspValid);

  // R3: response strobe follows exactly the accepted requests
  assert_resp_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
    rspValid == $past(accept));

  // R5: miss flag agrees with predicted vs resolved target
  assert_miss_flag_R5: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspMiss == (rspPredTarget != r1Tgt)));

  // R9: back-to-back same index sees the first write
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    (rspValid && r1Fire && r2Fire && (r1Idx == r2Idx)) |-> (rspPredTarget == r2Tgt));
endmodule

bind ibr_target_pred ibr_target_pred_chk #(
  .ADDR_W(ADDR_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .ALIGN_SHIFT(ALIGN_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqTarget(reqTarget), .ready(ready), .rspValid(rspValid),
  .rspMiss(rspMiss), .rspPredTarget(rspPredTarget)
);

// File: tb/ibr_target_pred_bench.sv
`timescale 1ns/1ps
module ibr_target_pred_bench;
  localparam int ADDR_W = 32;
  localparam int TGT_W  = 32;
  localparam int IDX_W  = 9;
  localparam int SHIFT  = 2;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [TGT_W-1:0]  reqTarget = '0;
  logic              ready, rspValid, rspMiss;
  logic [TGT_W-1:0]  rspPredTarget;

  int errors = 0;
  int checks = 0;
  logic [TGT_W-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  ibr_target_pred #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .ALIGN_SHIFT(SHIFT))
  u_ibr_target_pred (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqTarget(reqTarget), .ready(ready), .rspValid(rspValid),
    .rspMiss(rspMiss), .rspPredTarget(rspPredTarget)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idxOf(logic [ADDR_W-1:0] a);
    return int'(a[SHIFT +: IDX_W]);
  endfunction

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  // Reset, then count cycles until ready (R1)
  task automatic doReset();
    int n;
    @(negedge clk); rst = 1'b1; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelClear();
    check("R1 ready low after reset", ready, 0);
    check("R1 no response during reset", rspValid, 0);
    n = 0;
    while (!ready && n < DEPTH + 10) begin
      @(negedge clk); n++;
      if (rspValid) check("R1 no response during sweep", rspValid, 0);
    end
    check("R1 sweep length", n, DEPTH);
  endtask

  // One accepted lookup, checked against the model (R3, R5, R6)
  task automatic lookup(string req, logic [ADDR_W-1:0] a, logic [TGT_W-1:0] t);
    logic [TGT_W-1:0] exp;
    exp = model[idxOf(a)];
    reqValid = 1'b1; reqAddr = a; reqTarget = t;
    @(negedge clk);
    reqValid = 1'b0;
    model[idxOf(a)] = t;
    check({req, " valid"}, rspValid, 1);
    check({req, " pred"}, rspPredTarget, exp);
    check({req, " miss"}, rspMiss, exp != t);
    @(negedge clk);
    check({req, " R3 single-cycle valid"}, rspValid, 0);
  endtask

  task automatic testColdAndRepeat();
    lookup("R7 cold nonzero", 32'h0000_0100, 32'h4000_1000);
    lookup("R7 cold zero target", 32'h0000_0200, 32'h0);
    lookup("R5 repeat hit", 32'h0000_0100, 32'h4000_1000);
    lookup("R6 change after hit", 32'h0000_0100, 32'h4000_2000);
    lookup("R6 change after miss", 32'h0000_0100, 32'h4000_3000);
    lookup("R6 written after miss", 32'h0000_0100, 32'h4000_3000);
  endtask

  task automatic testIndexAndAlias();
    // R4: neighbouring entries (index field bits 10:2) are independent
    lookup("R4 entry 0x11", 32'h0000_0044, 32'hAAAA_0001);
    lookup("R4 entry 0x12", 32'h0000_0048, 32'hBBBB_0002);
    lookup("R4 entry 0x11 kept", 32'h0000_0044, 32'hAAAA_0001);
    // R8: above-index alias (bit 11 and up) and below-index alias (bits 1:0)
    lookup("R8 alias base", 32'h1000_0040, 32'h1111_1111);
    lookup("R8 alias high bits", 32'h2000_0840, 32'h2222_2222);
    lookup("R8 alias low bits", 32'h1000_0043, 32'h3333_3333);
    lookup("R8 alias back", 32'h1000_0040, 32'h3333_3333);
  endtask

  task automatic testBackToBack();
    reqValid = 1'b1; reqAddr = 32'h0000_0300; reqTarget = 32'h5555_0001;
    @(negedge clk);
    check("R9 first valid", rspValid, 1);
    check("R9 first pred", rspPredTarget, model[idxOf(32'h0000_0300)]);
    model[idxOf(32'h0000_0300)] = 32'h5555_0001;
    reqAddr = 32'h7000_0301; reqTarget = 32'h5555_0002;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 second valid", rspValid, 1);
    check("R9 second pred sees first write", rspPredTarget, 32'h5555_0001);
    check("R9 second miss", rspMiss, 1);
    model[idxOf(32'h0000_0300)] = 32'h5555_0002;
    @(negedge clk);
    lookup("R9 second write kept", 32'h0000_0300, 32'h5555_0002);
  endtask

  task automatic testBlockedAndReset();
    // R10: entries written earlier are zero after a new reset
    lookup("R10 prewrite", 32'h0000_0010, 32'h9999_0000);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; modelClear();
    // R2: request late in the sweep (after its index was cleared)
    repeat (DEPTH - 4) @(negedge clk);
    check("R2 still clearing", ready, 0);
    reqValid = 1'b1; reqAddr = 32'h0000_000C; reqTarget = 32'hDEAD_BEEF;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 no response when blocked", rspValid, 0);
    while (!ready) @(negedge clk);
    lookup("R2 blocked request left entry zero", 32'h0000_000C, 32'h0);
    lookup("R10 entry cleared by reset", 32'h0000_0010, 32'h0);
  endtask

  initial begin
    doReset();
    testColdAndRepeat();
    testIndexAndAlias();
    testBackToBack();
    testBlockedAndReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule